// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns parallel words into an asynchronous serial bit stream. A word is written into a one-entry holding register. When the shifter is free, the word moves into it and goes out as a framed character: a low start bit, the payload bits and a high stop bit. Framing comes in three flavours:

- a 10-bit frame with eight payload bits;
- an 11-bit frame that adds a ninth address or marker bit;
- an 11-bit frame that adds an even-parity bit.

A direction select chooses whether the payload leaves most-significant bit first or least-significant bit first. The extra ninth or parity bit always sits just before the stop bit.

A break control replaces normal characters with frames made entirely of zeros, so the receiver sees a missing stop bit. A frame already on the line always completes before a break starts. A short request yields exactly one zero frame. A held request yields zero frames back to back. When a break ends, the line goes high for one full bit time before any further start bit. Bit timing comes from an external baud tick, and each bit lasts a fixed whole number of ticks.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset and whenever no frame, break or recovery bit is in progress, the line output is 1, busy is 0 and ready is 1.
- R2: Format code 0 (and the unused code 3) sends a 10-bit frame: one 0 start bit, eight payload bits, then a 1 stop bit.
- R3: Format code 1 sends an 11-bit frame: start, eight payload bits, then write-data bit 8 as the address bit, then the stop bit.
- R4: Format code 2 sends an 11-bit frame: start, eight payload bits, then an even-parity bit (the XOR of write-data bits 7..0), then the stop bit.
- R5: With msb_first at 1 the payload leaves as bit 7 down to bit 0; with it at 0 it leaves as bit 0 up to bit 7. The address or parity bit stays directly before the stop bit in both orders.
- R6: Every bit, including the start bit and the recovery bit, stays on the line for exactly TICKS_PER_BIT baud ticks.
- R7: A write with ready at 1 loads the holding register and drops ready. Ready returns to 1 when the word moves to the shifter, so a word written during a frame follows it with no idle gap. A write while ready is 0 is dropped.
- R8: A break request made during a data frame takes effect only after that frame's stop bit. It takes precedence over a word waiting in the holding register.
- R9: A break request shorter than one frame produces exactly one zero frame: 10 zero bits in format codes 0 and 3, and 11 zero bits in codes 1 and 2.
- R10: While the break input stays at 1 at the end of a zero frame, another zero frame follows immediately, with no high bit between them.
- R11: After the last zero frame, the line is held at 1 for one bit time before any data start bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wdata | input | PAY_W+1 | Write word; bit PAY_W is the address bit for format code 1 |
| wr | input | 1 | Write strobe for the holding register |
| fmt | input | 2 | Framing select: 0/3 = 10-bit, 1 = 11-bit with address bit, 2 = 11-bit with even parity |
| msb_first | input | 1 | Payload order select: 1 sends MSB first |
| brk | input | 1 | Break request level |
| baud_tick | input | 1 | One-cycle baud rate pulse |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame, break or recovery bit is in progress |
| ready | output | 1 | Holding register can accept a write |

## Verification
The properties assume that baud_tick is a single-cycle pulse. They also assume that fmt and msb_first do not change between a write and the moment that word is moved into the shifter, because both selects are sampled at the move. The stimulus changes the selects only after busy has dropped and ready is high. It drives ticks from a free-running divider, so every bit sees the same tick spacing. Break requests are either short pulses, well under one frame long, or a level released in the middle of a zero frame. This keeps the expected number of zero frames well defined.

// File: rtl/brk_uart_tx_pkg.sv
package brk_uart_tx_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_BRK  = 2'd2,
    S_MARK = 2'd3
  } tx_state_e;

  localparam logic [1:0] FMT_TEN  = 2'd0;
  localparam logic [1:0] FMT_NINE = 2'd1;
  localparam logic [1:0] FMT_PAR  = 2'd2;
endpackage

// File: rtl/brk_uart_tx_frame.sv
module brk_uart_tx_frame
  import brk_uart_tx_pkg::*;
#(
  parameter int PAY_W = 8
) (
  input  logic [PAY_W:0]   word,
  input  logic [1:0]       fmt,
  input  logic             msb_first,
  input  logic             blank,
  output logic [PAY_W+2:0] frame,
  output logic             long_fmt
);
  logic [PAY_W-1:0] pay;
  logic             extra;

  // payload order: index 0 is the first payload bit on the line
  for (genvar i = 0; i < PAY_W; i++) begin : g_order
    assign pay[i] = msb_first ? word[PAY_W-1-i] : word[i];
  end

  always_comb begin
    long_fmt = (fmt == FMT_NINE) || (fmt == FMT_PAR);
    extra    = (fmt == FMT_NINE) ? word[PAY_W] : ^word[PAY_W-1:0];
    if (blank) begin
      frame = '0;
    end else if (long_fmt) begin
      frame = {1'b1, extra, pay, 1'b0};
    end else begin
      frame = {1'b1, 1'b1, pay, 1'b0};
    end
  end
endmodule

// File: rtl/brk_uart_tx_timer.sv
module brk_uart_tx_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign bit_end = run && tick && (cnt_q == LAST);
  assign cnt_en  = !run || tick;

  always_comb begin
    if (!run || bit_end) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
  import brk_uart_tx_pkg::*;
#(
  parameter int PAY_W         = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PAY_W:0] wdata,
  input  logic           wr,
  input  logic [1:0]     fmt,
  input  logic           msb_first,
  input  logic           brk,
  input  logic           baud_tick,
  output logic           txd,
  output logic           busy,
  output logic           ready
);
  localparam int FRAME_W = PAY_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(FRAME_W - 2);

  tx_state_e          st_q, st_d;
  logic [FRAME_W-2:0] sh_q, sh_d;
  logic [IDX_W-1:0]   bidx_q, bidx_d;
  logic               txd_q, txd_d;
  logic               long_q, long_d;
  logic [PAY_W:0]     hold_q;
  logic               full_q, full_d;
  logic               pend_q, pend_d;

  logic               bit_end, last_bit, free, req_brk;
  logic               start_brk, start_dat, hold_en, line_en;
  logic [FRAME_W-1:0] frame;
  logic               long_fmt;

  brk_uart_tx_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q != S_IDLE),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  brk_uart_tx_frame #(.PAY_W(PAY_W)) i_frame (
    .word      (hold_q),
    .fmt       (fmt),
    .msb_first (msb_first),
    .blank     (start_brk),
    .frame     (frame),
    .long_fmt  (long_fmt)
  );

  assign last_bit  = (bidx_q == (long_q ? LAST_LONG : LAST_SHORT));
  assign req_brk   = brk || pend_q;
  assign free      = (st_q == S_IDLE)
                  || (st_q == S_DATA && bit_end && last_bit)
                  || (st_q == S_MARK && bit_end);
  assign start_brk = (free && req_brk)
                  || (st_q == S_BRK && bit_end && last_bit && brk);
  assign start_dat = free && !req_brk && full_q;
  assign hold_en   = wr && !full_q;
  assign line_en   = start_brk || start_dat || bit_end || (st_q == S_IDLE);

  // next-state logic for the frame sequencer
  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bidx_d = bidx_q;
    txd_d  = txd_q;
    long_d = long_q;
    if (start_brk || start_dat) begin
      st_d   = start_brk ? S_BRK : S_DATA;
      sh_d   = frame[FRAME_W-1:1];
      txd_d  = frame[0];
      bidx_d = '0;
      long_d = long_fmt;
    end else if (st_q == S_BRK && bit_end && last_bit) begin
      st_d  = S_MARK;
      txd_d = 1'b1;
    end else if (free) begin
      st_d  = S_IDLE;
      txd_d = 1'b1;
    end else if (bit_end) begin
      sh_d   = {1'b0, sh_q[FRAME_W-2:1]};
      txd_d  = sh_q[0];
      bidx_d = bidx_q + 1'b1;
    end
  end

  always_comb begin
    full_d = full_q;
    if (hold_en)        full_d = 1'b1;
    else if (start_dat) full_d = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (start_brk)                  pend_d = 1'b0;
    else if (brk && st_q != S_BRK)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      bidx_q <= '0;
      txd_q  <= 1'b1;
      long_q <= 1'b0;
    end else if (line_en) begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bidx_q <= bidx_d;
      txd_q  <= txd_d;
      long_q <= long_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= wdata;
  end

  assign txd   = txd_q;
  assign busy  = (st_q != S_IDLE);
  assign ready = !full_q;
endmodule

// File: rtl/brk_uart_tx_chk.sv
module brk_uart_tx_chk
  import brk_uart_tx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      wr,
  input logic      txd,
  input logic      busy,
  input logic      ready,
  input tx_state_e st
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) != S_DATA) |-> !txd); // R2

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ready) |=> !ready); // R7

  AST_FREE_MEANS_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy); // R7

  AST_BREAK_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRK) |-> !txd); // R9

  AST_RECOVERY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MARK) |-> txd); // R11

  AST_NO_DATA_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_BRK) |-> (st != S_DATA)); // R11
endmodule

bind brk_uart_tx brk_uart_tx_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .wr    (wr),
  .txd   (txd),
  .busy  (busy),
  .ready (ready),
  .st    (st_q)
);

// File: tb/test_brk_uart_tx.sv
`timescale 1ns/1ps
module test_brk_uart_tx;
  localparam int PAY_W = 8;
  localparam int TPB   = 2;

  typedef struct {
    logic [12:0] bits;
    int          n;
    string       tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [PAY_W:0] wdata = '0;
  logic           wr = 1'b0;
  logic [1:0]     fmt = 2'd0;
  logic           msb_first = 1'b0;
  logic           brk = 1'b0;
  logic           baud_tick = 1'b0;
  logic           txd, busy, ready;

  int   n_chk = 0;
  int   n_bad = 0;
  int   div = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  brk_uart_tx #(.PAY_W(PAY_W), .TICKS_PER_BIT(TPB)) i_brk_uart_tx (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .wr(wr), .fmt(fmt),
    .msb_first(msb_first), .brk(brk), .baud_tick(baud_tick),
    .txd(txd), .busy(busy), .ready(ready)
  );

  initial begin
    forever begin
      @(posedge clk);
      div       <= (div == 3) ? 0 : div + 1;
      baud_tick <= (div == 3);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t data_item(input logic [PAY_W:0] d, input logic [1:0] f,
                                     input logic m, input string tag);
    exp_t e;
    e.bits = '0;
    e.tag  = tag;
    e.bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) e.bits[1+i] = m ? d[7-i] : d[i];
    if (f == 2'd1 || f == 2'd2) begin
      e.bits[9]  = (f == 2'd1) ? d[8] : ^d[7:0];
      e.bits[10] = 1'b1;
      e.n = 11;
    end else begin
      e.bits[9] = 1'b1;
      e.n = 10;
    end
    return e;
  endfunction

  function automatic exp_t brk_item(input int zeros, input bit mark, input string tag);
    exp_t e;
    e.bits = '0;
    e.tag  = tag;
    e.n    = zeros + (mark ? 1 : 0);
    if (mark) e.bits[zeros] = 1'b1;
    return e;
  endfunction

  task automatic write_raw(input logic [PAY_W:0] d);
    @(negedge clk);
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic send(input logic [PAY_W:0] d, input string tag);
    while (!ready) @(negedge clk);
    q.push_back(data_item(d, fmt, msb_first, tag));
    write_raw(d);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || !ready);
    repeat (4) @(negedge clk);
  endtask

  task automatic brk_pulse();
    @(negedge clk);
    brk = 1'b1;
    repeat (3) @(negedge clk);
    brk = 1'b0;
  endtask

  task automatic next_sample(output logic v);
    do @(negedge clk); while (!baud_tick);
    v = txd;
  endtask

  // monitor: decodes the line on baud ticks and compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && baud_tick && !txd) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected start", 0, 1);
        end else begin
          exp_t        e;
          logic [12:0] act;
          logic        v;
          bit          ok;
          e      = q.pop_front();
          ok     = 1'b1;
          act    = '0;
          for (int b = 0; b < e.n; b++) begin
            for (int s = 0; s < TPB; s++) begin
              if (b == 0 && s == 0) v = 1'b0;
              else next_sample(v);
              if (v !== e.bits[b]) ok = 1'b0;
              act[b] = v;
            end
          end
          check(ok, e.tag, int'(act), int'(e.bits));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(txd === 1'b1, "R1 reset line", int'(txd), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R6: ten-bit frame, LSB first
    fmt = 2'd0; msb_first = 1'b0;
    send(9'h0A5, "R2 R6 ten-bit lsb");
    wait_idle();
    // R5: MSB first
    msb_first = 1'b1;
    send(9'h03C, "R5 ten-bit msb");
    wait_idle();
    // R2: unused code 3 acts as ten-bit
    fmt = 2'd3; msb_first = 1'b0;
    send(9'h0C1, "R2 code3 ten-bit");
    wait_idle();
    // R3 R5: address bit in both orders
    fmt = 2'd1; msb_first = 1'b0;
    send(9'h15A, "R3 addr lsb");
    wait_idle();
    msb_first = 1'b1;
    send(9'h081, "R3 R5 addr msb");
    wait_idle();
    // R4: even parity
    fmt = 2'd2; msb_first = 1'b0;
    send(9'h007, "R4 parity odd count");
    wait_idle();
    msb_first = 1'b1;
    send(9'h00F, "R4 R5 parity even count");
    wait_idle();

    // R7: back-to-back with a dropped write
    fmt = 2'd0; msb_first = 1'b0;
    send(9'h011, "R7 first");
    send(9'h0EE, "R7 second no gap");
    @(negedge clk);
    check(ready === 1'b0, "R7 held word", int'(ready), 0);
    write_raw(9'h055);
    check(ready === 1'b0, "R7 dropped write", int'(ready), 0);
    wait_idle();

    // R9: single short break, ten and eleven zeros
    q.push_back(brk_item(10, 1'b1, "R9 R11 short break ten"));
    brk_pulse();
    wait_idle();
    fmt = 2'd1;
    q.push_back(brk_item(11, 1'b1, "R9 R11 short break eleven"));
    brk_pulse();
    wait_idle();

    // R8 R11: break during a frame, ahead of a waiting word
    fmt = 2'd0;
    send(9'h0B2, "R8 frame completes");
    do @(negedge clk); while (!busy || !ready);
    write_raw(9'h04D);
    q.push_back(brk_item(10, 1'b1, "R8 R11 break after frame"));
    q.push_back(data_item(9'h04D, fmt, msb_first, "R11 word after recovery"));
    brk_pulse();
    wait_idle();

    // R10: held break, released mid third frame
    q.push_back(brk_item(10, 1'b0, "R10 held frame 1"));
    q.push_back(brk_item(10, 1'b0, "R10 held frame 2"));
    q.push_back(brk_item(10, 1'b1, "R10 R11 held frame 3"));
    @(negedge clk);
    brk = 1'b1;
    repeat (200) @(negedge clk);
    brk = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);

    check(q.size() == 0, "R9 R10 all frames seen", q.size(), 0);
    check(txd === 1'b1 && !busy && ready, "R1 final idle", int'(txd), 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule